// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a video output. A pixel-rate clock drives a horizontal counter and a vertical counter. Every timing point is programmed as an inclusive last-count value: the line length, the visible width, where each sync pulse starts and ends, and the point that raises an early prefetch strobe once per line. From the counters the block derives a display-enable flag, horizontal and vertical sync, and the prefetch strobe.

Software loads a shadow register set through a one-cycle write port. The counters run from a separate active copy. The active copy takes the shadow values only at a frame boundary, or on every cycle while the generator is idle. A retimed mode therefore never shows a torn frame. Sync control selects the polarity of each sync, suppresses either sync or both for power-saving blanking, and can merge both syncs onto one composite output. A separate display-off bit blanks the video while the syncs keep running.

The controller has two states. In `ST_IDLE` the counters are held at zero and the active copy follows the shadow copy. In `ST_RUN` the counters scan. The transition `IDLE->RUN` is taken when the shadow timing-enable bit is 1. The transition `RUN->IDLE` is taken at the end of a frame when the shadow timing-enable bit is 0.

Top module: `disp_timing_gen`

## Requirements
- R1: Register addresses on `wr_addr`: 0 control, 1 line last count, 2 visible-width last count, 3 hsync start, 4 hsync end, 5 frame last line, 6 visible-height last line, 7 vsync start, 8 vsync end, 9 prefetch position, 10 sync control, 11 display control. Writes to any other address are ignored. While running, `h_count` counts 0 up to the line last count and then wraps to 0. `v_count` advances on each wrap of `h_count` and wraps to 0 after the frame last line.
- R2: `de` is 1 only while running, with `h_count` ≤ visible-width last count and `v_count` ≤ visible-height last line.
- R3: The raw horizontal sync pulse is active when `h_count` is strictly greater than the hsync start and less than or equal to the hsync end. The vertical pulse follows the same rule using `v_count` and the vsync start and end.
- R4: Sync control bit 3 inverts `hsync` and bit 4 inverts `vsync`. With a bit at 0, an active pulse reads as 1 on its pin.
- R5: Sync control bit 1 suppresses both syncs, bit 5 suppresses only hsync and bit 6 suppresses only vsync. A suppressed sync stays at its inactive level.
- R6: When sync control bit 0 is set, `hsync` carries the OR of both raw pulses (after suppression) with the bit-3 polarity, and `vsync` is held at its inactive level.
- R7: Display control bit 1 forces `de` low while the counters and syncs keep running.
- R8: `prefetch` is high for exactly the cycles in which a running `h_count` equals the prefetch position, once per line.
- R9: Control bit 0 enables timing and control bit 1 enables screen refresh. `de` requires bit 1. After bit 0 is cleared, the current frame completes. The block then idles with both counters at 0, `de` and `prefetch` low, and both syncs at their inactive levels.
- R10: Register writes take effect only when the counters wrap to the start of a frame, or at once while idle.
- R11: After reset all registers are 0, the block is idle, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register address |
| wr_data | input | CNT_W (12) | Register write data |
| h_count | output | CNT_W (12) | Horizontal position |
| v_count | output | CNT_W (12) | Vertical position |
| de | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync, or composite sync |
| vsync | output | 1 | Vertical sync |
| prefetch | output | 1 | Per-line early fetch strobe |

## Verification
The bench programs a small 10x6 raster, so that every sync edge and wrap point is visited within a few frames. It compares each output on every cycle against its own model of the state, counters and register copies. The patterns used are:
- Plain scanning shows the counting, enable and prefetch behaviour.
- Each polarity setting, each suppression bit and composite mode is tried on its own, so an error in one sync path cannot be hidden by another.
- A write made in the middle of a frame separates deferred updates from immediate ones.
- Clearing the enable in the middle of a frame separates a stop at the frame end from an abrupt stop.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dtg_state_e;

    localparam int NUM_REGS    = 12;
    localparam int REG_CTRL    = 0;
    localparam int REG_HTOT    = 1;
    localparam int REG_HACT    = 2;
    localparam int REG_HS_BEG  = 3;
    localparam int REG_HS_END  = 4;
    localparam int REG_VTOT    = 5;
    localparam int REG_VACT    = 6;
    localparam int REG_VS_BEG  = 7;
    localparam int REG_VS_END  = 8;
    localparam int REG_PF      = 9;
    localparam int REG_SYNC    = 10;
    localparam int REG_DISP    = 11;

    localparam int CTRL_EN     = 0;
    localparam int CTRL_REFR   = 1;
    localparam int SC_COMP     = 0;
    localparam int SC_OFF_ALL  = 1;
    localparam int SC_INV_H    = 3;
    localparam int SC_INV_V    = 4;
    localparam int SC_OFF_H    = 5;
    localparam int SC_OFF_V    = 6;
    localparam int DC_BLANK    = 1;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs #(
    parameter int DW     = 12,
    parameter int NREG   = 12,
    parameter int AW     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     load,
    output logic [NREG-1:0][DW-1:0]  shadow_q,
    output logic [NREG-1:0][DW-1:0]  active_q
);
    // Shadow set takes writes; active set copies it when load is high.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end else begin
                if (wr_en && (wr_addr == AW'(i)))
                    shadow_q[i] <= wr_data;
                if (load)
                    active_q[i] <= shadow_q[i];
            end
        end
    end
endmodule

// File: rtl/dtg_window.sv
module dtg_window #(
    parameter int W = 12
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] first_excl,
    input  logic [W-1:0] last_incl,
    output logic         hit
);
    // R3: pulse window is (start, end]
    always_comb hit = (cnt > first_excl) && (cnt <= last_incl);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  h_count,
    output logic [CNT_W-1:0]  v_count,
    output logic              de,
    output logic              hsync,
    output logic              vsync,
    output logic              prefetch
);
    dtg_state_e state_q, state_nx;
    logic [NUM_REGS-1:0][CNT_W-1:0] sh_q, act_q;
    logic [CNT_W-1:0] h_q, v_q;
    logic line_end, frame_end, load, running;
    logic h_win, v_win, h_raw, v_raw;
    logic [CNT_W-1:0] sc, ctl, dc;

    assign sc  = act_q[REG_SYNC];
    assign ctl = act_q[REG_CTRL];
    assign dc  = act_q[REG_DISP];

    assign running   = (state_q == ST_RUN);
    assign line_end  = (h_q == act_q[REG_HTOT]);
    assign frame_end = line_end && (v_q == act_q[REG_VTOT]);
    // R10: active copy follows shadow only while idle or at frame wrap
    assign load      = !running || frame_end;

    dtg_regs #(.DW(CNT_W), .NREG(NUM_REGS), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(load), .shadow_q(sh_q), .active_q(act_q)
    );

    dtg_window #(.W(CNT_W)) u_hwin (
        .cnt(h_q), .first_excl(act_q[REG_HS_BEG]), .last_incl(act_q[REG_HS_END]), .hit(h_win)
    );
    dtg_window #(.W(CNT_W)) u_vwin (
        .cnt(v_q), .first_excl(act_q[REG_VS_BEG]), .last_incl(act_q[REG_VS_END]), .hit(v_win)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Transitions: IDLE->RUN on shadow enable, RUN->IDLE at frame end without it
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (sh_q[REG_CTRL][CTRL_EN]) state_nx = ST_RUN;
            ST_RUN:  if (frame_end && !sh_q[REG_CTRL][CTRL_EN]) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // R1: raster counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (!running) begin
            h_q <= '0;
            v_q <= '0;
        end else if (line_end) begin
            h_q <= '0;
            v_q <= frame_end ? '0 : v_q + 1'b1;
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        h_raw    = running && h_win && !sc[SC_OFF_ALL] && !sc[SC_OFF_H];
        v_raw    = running && v_win && !sc[SC_OFF_ALL] && !sc[SC_OFF_V];
        de       = running && ctl[CTRL_REFR] && !dc[DC_BLANK]
                   && (h_q <= act_q[REG_HACT]) && (v_q <= act_q[REG_VACT]);
        prefetch = running && (h_q == act_q[REG_PF]);
        if (sc[SC_COMP]) begin
            hsync = (h_raw || v_raw) ^ sc[SC_INV_H];
            vsync = sc[SC_INV_V];
        end else begin
            hsync = h_raw ^ sc[SC_INV_H];
            vsync = v_raw ^ sc[SC_INV_V];
        end
    end

    assign h_count = h_q;
    assign v_count = v_q;

    // R1: line wrap
    a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (running && line_end) |=> (h_q == '0));
    // R1: plain increment
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !line_end && state_nx == ST_RUN) |=> (h_q == $past(h_q) + 1'b1));
    // R9: idle keeps everything quiet
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!running) |-> (h_q == '0 && v_q == '0 && !de && !prefetch));
    // R7: display-off blanks video
    a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
        dc[DC_BLANK] |-> !de);
    // R10: active set stable mid-line
    a_r10_no_tear: assert property (@(posedge clk) disable iff (!rst_n)
        (running && h_q != '0) |-> $stable(act_q));
endmodule

// File: tb/sim_disp_timing_gen.sv
module sim_disp_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] h_count, v_count;
    logic de, hsync, vsync, prefetch;

    int n_checks = 0;
    int n_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .h_count(h_count), .v_count(v_count), .de(de), .hsync(hsync),
        .vsync(vsync), .prefetch(prefetch)
    );

    // Bench model of the requirements
    logic [W-1:0] m_sh [12];
    logic [W-1:0] m_ac [12];
    logic         m_run;
    logic [W-1:0] m_h, m_v;

    function automatic logic [4:0] expect_out();
        logic hr, vr, e_de, e_hs, e_vs, e_pf;
        logic [W-1:0] sc;
        sc   = m_ac[10];
        hr   = m_run && m_h > m_ac[3] && m_h <= m_ac[4] && !sc[1] && !sc[5];
        vr   = m_run && m_v > m_ac[7] && m_v <= m_ac[8] && !sc[1] && !sc[6];
        e_de = m_run && m_ac[0][1] && !m_ac[11][1] && m_h <= m_ac[2] && m_v <= m_ac[6];
        e_pf = m_run && m_h == m_ac[9];
        if (sc[0]) begin
            e_hs = (hr | vr) ^ sc[3];
            e_vs = sc[4];
        end else begin
            e_hs = hr ^ sc[3];
            e_vs = vr ^ sc[4];
        end
        return {e_de, e_hs, e_vs, e_pf, 1'b0};
    endfunction

    task automatic model_step(input logic we, input logic [3:0] a, input logic [W-1:0] d);
        if (!m_run) begin
            for (int i = 0; i < 12; i++) m_ac[i] = m_sh[i];
            m_h = '0;
            m_v = '0;
            if (m_sh[0][0]) m_run = 1'b1;
        end else if (m_h == m_ac[1]) begin
            m_h = '0;
            if (m_v == m_ac[5]) begin
                m_v = '0;
                for (int i = 0; i < 12; i++) m_ac[i] = m_sh[i];
                if (!m_sh[0][0]) m_run = 1'b0;
            end else begin
                m_v = m_v + 1'b1;
            end
        end else begin
            m_h = m_h + 1'b1;
        end
        if (we && a < 12) m_sh[a] = d;
    endtask

    task automatic compare(input string tag);
        logic [4:0] e;
        e = expect_out();
        n_checks++;
        if (h_count !== m_h || v_count !== m_v || de !== e[4] || hsync !== e[3]
            || vsync !== e[2] || prefetch !== e[1]) begin
            n_fails++;
            $display("FAIL %s: h=%0d v=%0d de=%b hs=%b vs=%b pf=%b expected h=%0d v=%0d de=%b hs=%b vs=%b pf=%b",
                     tag, h_count, v_count, de, hsync, vsync, prefetch,
                     m_h, m_v, e[4], e[3], e[2], e[1]);
        end
    endtask

    // One clock: check at negedge, drive, cross posedge, advance model
    task automatic tick(input string tag, input logic we, input logic [3:0] a, input logic [W-1:0] d);
        compare(tag);
        wr_en = we;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        model_step(we, a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input string tag, input logic [3:0] a, input logic [W-1:0] d);
        tick(tag, 1'b1, a, d);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag, 1'b0, 4'd0, '0);
    endtask

    task automatic t_reset();
        n_checks++;
        if (h_count !== 0 || v_count !== 0 || de !== 0 || hsync !== 0 || vsync !== 0 || prefetch !== 0) begin
            n_fails++;
            $display("FAIL R11 reset: h=%0d v=%0d de=%b hs=%b vs=%b pf=%b expected all 0",
                     h_count, v_count, de, hsync, vsync, prefetch);
        end
    endtask

    task automatic t_basic();
        wr("R1", 4'd1, 12'd9);  wr("R1", 4'd2, 12'd5);
        wr("R3", 4'd3, 12'd6);  wr("R3", 4'd4, 12'd7);
        wr("R1", 4'd5, 12'd5);  wr("R2", 4'd6, 12'd2);
        wr("R3", 4'd7, 12'd3);  wr("R3", 4'd8, 12'd4);
        wr("R8", 4'd9, 12'd8);  wr("R1", 4'd13, 12'd7);
        wr("R9", 4'd0, 12'd3);
        idle("R1 R2 R3 R8 scan", 130);
    endtask

    task automatic t_polarity();
        wr("R4", 4'd10, 12'h008); idle("R4 hsync inverted", 70);
        wr("R4", 4'd10, 12'h010); idle("R4 vsync inverted", 70);
    endtask

    task automatic t_suppress();
        wr("R5", 4'd10, 12'h002); idle("R5 both off", 70);
        wr("R5", 4'd10, 12'h020); idle("R5 hsync off", 70);
        wr("R5", 4'd10, 12'h058); idle("R5 vsync off inverted", 70);
    endtask

    task automatic t_composite();
        wr("R6", 4'd10, 12'h001); idle("R6 composite", 70);
        wr("R6", 4'd10, 12'h019); idle("R6 composite inverted", 70);
        wr("R6", 4'd10, 12'h000); idle("R6 back to separate", 70);
    endtask

    task automatic t_blank();
        wr("R7", 4'd11, 12'h002); idle("R7 display off", 70);
        wr("R7", 4'd11, 12'h000); idle("R7 display on", 70);
    endtask

    task automatic t_deferred();
        idle("R10 align", 25);
        wr("R10", 4'd2, 12'd2);
        wr("R10", 4'd9, 12'd3);
        idle("R10 deferred", 100);
    endtask

    task automatic t_stop();
        idle("R9 align", 17);
        wr("R9", 4'd0, 12'd2);
        idle("R9 stop at frame end", 100);
        wr("R9", 4'd0, 12'd1);
        idle("R9 refresh off", 70);
    endtask

    initial begin
        for (int i = 0; i < 12; i++) begin
            m_sh[i] = '0;
            m_ac[i] = '0;
        end
        m_run = 1'b0;
        m_h = '0;
        m_v = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        model_step(1'b0, 4'd0, '0);
        t_basic();
        t_polarity();
        t_suppress();
        t_composite();
        t_blank();
        t_deferred();
        t_stop();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule